// File: doc/BRIEF.md
# PWM Output Run/Idle/Fault Controller

This block is the final stage in front of a pair of timer output pins. Each output has its own state: IDLE, RUN or FAULT. In IDLE the pin drives a programmed idle level. In RUN the pin follows an internal set/reset waveform level, passed through a per-output polarity bit. In FAULT the pin takes a level chosen by a 2-bit fault code, or is released to tri-state. Software strobes move an output between states. Fault inputs and a debug-halt request move running outputs into FAULT automatically.

The internal level is held in a set/reset register. Hardware set and reset events reach it only while the timer's counter-enable flag is high. The software set and reset strobes always reach it. This level keeps updating in every state. A re-enabled output therefore shows the current waveform at once. The counter-enable flag also gates the burst-idle request and the burst counter-reset request. A debug halt with stop enabled latches running outputs into FAULT. That FAULT state stays until software enables the output again or disables it.

Top module: `pwm_out_stage`

## Requirements
- R1: While `rst_n` is low every `pin_oe` bit is 0 and every `pin_val` bit is 0. After reset each output is in IDLE, each internal level is 0 and `flt_stat` is all zeros.
- R2: In IDLE, an output drives `pin_oe`=1 and `pin_val` equal to its `idle_lvl` bit. `out_state` codes are 2'b00 IDLE, 2'b01 RUN and 2'b10 FAULT, two bits per output, with output g at bits [2g+1:2g]. The code 2'b11 never appears.
- R3: A high `oe_set` bit moves that output to RUN on the next cycle, from IDLE or from FAULT. A high `oe_clr` bit moves it to IDLE on the next cycle. When both are high, `oe_clr` wins.
- R4: The internal level of an output is set by `sw_set`, or by `wave_set` while `cnt_en`=1. It is cleared by `sw_rst`, or by `wave_rst` while `cnt_en`=1. A reset wins over a set in the same cycle. While `cnt_en`=0, `wave_set` and `wave_rst` have no effect. The level updates in every state.
- R5: In RUN, `pin_val` equals the internal level XOR `pol`. With `pol`=0, level 1 drives the pin high. Straight after the first enable the pin is at its inactive level, which equals `pol`, until the first valid event.
- R6: In RUN with `cnt_en`=1 and `burst_idle`=1, the pin shows its `idle_lvl` and the state stays RUN. `burst_idle` has no effect while `cnt_en`=0. `cnt_rst_out` follows `burst_cnt_rst` only while `cnt_en`=1 and is 0 otherwise.
- R7: When any `fault_in` bit is high, each output in RUN, or being enabled that cycle, whose fault code in `flt_mode` bits [2g+1:2g] is nonzero enters FAULT on the next cycle. That move happens unless `oe_clr` is high. An output with code 00 stays in RUN and keeps following its level.
- R8: In FAULT the pin depends on the fault code. Code 01 drives the active level (~`pol`). Codes 10 and 00 drive the inactive level (`pol`). Code 11 gives `pin_oe`=0 and `pin_val`=0.
- R9: A rising edge of `dbg_halt` while `dbg_stop_en`=1 acts like a fault for that cycle, under the rule of R7. Outputs in IDLE stay in IDLE. With `dbg_stop_en`=0 the halt has no effect.
- R10: FAULT persists after the halt or fault ends. It is left only through `oe_set` or `oe_clr`. On re-enable, the pin shows the current internal level from the next cycle.
- R11: Bit k of `flt_stat` is set on the cycle after `fault_in[k]` is high, including during a debug halt. It is cleared by `flt_clr[k]` only when `fault_in[k]` is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; pins tri-stated while low |
| cnt_en | input | 1 | Timer counter enable; gates hardware events and burst requests |
| wave_set | input | N_OUT | Hardware set event per output |
| wave_rst | input | N_OUT | Hardware reset event per output |
| sw_set | input | N_OUT | Software set strobe per output |
| sw_rst | input | N_OUT | Software reset strobe per output |
| burst_idle | input | N_OUT | Burst-mode idle request per output |
| burst_cnt_rst | input | 1 | Burst-mode counter-reset request |
| oe_set | input | N_OUT | Output enable strobe (to RUN) |
| oe_clr | input | N_OUT | Output disable strobe (to IDLE) |
| pol | input | N_OUT | Polarity per output; also the inactive pin level |
| idle_lvl | input | N_OUT | Pin level in IDLE |
| flt_mode | input | 2*N_OUT | 2-bit fault code per output |
| fault_in | input | N_FLT | Fault inputs |
| flt_clr | input | N_FLT | Fault status clear strobes |
| dbg_stop_en | input | 1 | Debug stop enable |
| dbg_halt | input | 1 | Debug halt indication |
| pin_val | output | N_OUT | Pin level |
| pin_oe | output | N_OUT | Pin driven (1) or tri-stated (0) |
| out_state | output | 2*N_OUT | Per-output state code |
| flt_stat | output | N_FLT | Sticky fault status |
| cnt_rst_out | output | 1 | Gated counter-reset request |

## Verification
The bench builds the block with N_OUT=2 and N_FLT=2. It gives the two outputs opposite polarities, opposite idle levels and different fault codes. So one stimulus shows an output with a nonzero code trip while its neighbour with code 00 stays in RUN. It also shows both pin levels through the polarity path. Two fault sources bring independent set, clear and set-wins behaviour of the status bits within reach. A debug halt with one output in IDLE and the other in RUN shows the trip, and the IDLE output being left alone, in the same run.

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int N_OUT = 2,
  parameter int N_FLT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_en,
  input  logic [N_OUT-1:0]   wave_set,
  input  logic [N_OUT-1:0]   wave_rst,
  input  logic [N_OUT-1:0]   sw_set,
  input  logic [N_OUT-1:0]   sw_rst,
  input  logic [N_OUT-1:0]   burst_idle,
  input  logic               burst_cnt_rst,
  input  logic [N_OUT-1:0]   oe_set,
  input  logic [N_OUT-1:0]   oe_clr,
  input  logic [N_OUT-1:0]   pol,
  input  logic [N_OUT-1:0]   idle_lvl,
  input  logic [2*N_OUT-1:0] flt_mode,
  input  logic [N_FLT-1:0]   fault_in,
  input  logic [N_FLT-1:0]   flt_clr,
  input  logic               dbg_stop_en,
  input  logic               dbg_halt,
  output logic [N_OUT-1:0]   pin_val,
  output logic [N_OUT-1:0]   pin_oe,
  output logic [2*N_OUT-1:0] out_state,
  output logic [N_FLT-1:0]   flt_stat,
  output logic               cnt_rst_out
);
  localparam logic [1:0] S_IDLE = 2'b00;
  localparam logic [1:0] S_RUN  = 2'b01;
  localparam logic [1:0] S_FLT  = 2'b10;

  logic halt_q;
  logic trip;

  assign trip        = (dbg_stop_en & dbg_halt & ~halt_q) | (|fault_in);
  assign cnt_rst_out = cnt_en & burst_cnt_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q   <= 1'b0;
      flt_stat <= '0;
    end else begin
      halt_q   <= dbg_halt;
      flt_stat <= (flt_stat & ~flt_clr) | fault_in;
    end
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    logic [1:0] st_q, st_d, fm;
    logic       lvl_q, set_ev, rst_ev, val, oe;

    assign fm     = flt_mode[2*g +: 2];
    assign set_ev = sw_set[g] | (cnt_en & wave_set[g]);
    assign rst_ev = sw_rst[g] | (cnt_en & wave_rst[g]);

    always_comb begin
      st_d = st_q;
      if (oe_clr[g])
        st_d = S_IDLE;
      else if (trip && fm != 2'b00 && (st_q != S_IDLE || oe_set[g]))
        st_d = S_FLT;
      else if (oe_set[g])
        st_d = S_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= S_IDLE;
        lvl_q <= 1'b0;
      end else begin
        st_q <= st_d;
        if (rst_ev)      lvl_q <= 1'b0;
        else if (set_ev) lvl_q <= 1'b1;
      end
    end

    always_comb begin
      oe  = 1'b1;
      val = idle_lvl[g];
      if (st_q == S_RUN) begin
        val = (cnt_en & burst_idle[g]) ? idle_lvl[g] : (lvl_q ^ pol[g]);
      end else if (st_q == S_FLT) begin
        val = (fm == 2'b01) ? ~pol[g] : pol[g];
        oe  = (fm != 2'b11);
      end
    end

    assign pin_oe[g]          = rst_n & oe;
    assign pin_val[g]         = rst_n & oe & val;
    assign out_state[2*g +: 2] = st_q;
  end
endmodule

module pwm_out_stage_chk #(
  parameter int N_OUT = 2,
  parameter int N_FLT = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_OUT-1:0]   oe_set,
  input logic [N_OUT-1:0]   oe_clr,
  input logic [2*N_OUT-1:0] flt_mode,
  input logic [N_FLT-1:0]   fault_in,
  input logic [N_OUT-1:0]   pin_oe,
  input logic [2*N_OUT-1:0] out_state,
  input logic [N_FLT-1:0]   flt_stat
);
  p_reset_tristate_r1: assert property (@(posedge clk) !rst_n |-> pin_oe == '0);

  for (genvar g = 0; g < N_OUT; g++) begin : g_chk
    p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_state[2*g +: 2] != 2'b11);
    p_clr_to_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      oe_clr[g] |=> out_state[2*g +: 2] == 2'b00);
    p_fault_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_state[2*g +: 2] == 2'b01 && |fault_in && flt_mode[2*g +: 2] != 2'b00 && !oe_clr[g])
      |=> out_state[2*g +: 2] == 2'b10);
    p_tri_in_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_state[2*g +: 2] == 2'b10 && flt_mode[2*g +: 2] == 2'b11) |-> !pin_oe[g]);
    p_idle_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_state[2*g +: 2] == 2'b00 && !oe_set[g]) |=> out_state[2*g +: 2] == 2'b00);
    p_fault_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_state[2*g +: 2] == 2'b10 && !oe_set[g] && !oe_clr[g]) |=> out_state[2*g +: 2] == 2'b10);
  end

  for (genvar k = 0; k < N_FLT; k++) begin : g_stat
    p_stat_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fault_in[k] |=> flt_stat[k]);
  end
endmodule

bind pwm_out_stage pwm_out_stage_chk #(.N_OUT(N_OUT), .N_FLT(N_FLT)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_set(oe_set), .oe_clr(oe_clr), .flt_mode(flt_mode),
  .fault_in(fault_in), .pin_oe(pin_oe), .out_state(out_state), .flt_stat(flt_stat)
);

// File: tb/pwm_out_stage_bench.sv
`timescale 1ns/1ps
module pwm_out_stage_bench;
  localparam int NO = 2;
  localparam int NF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, burst_cnt_rst = 1'b0, dbg_stop_en = 1'b0, dbg_halt = 1'b0;
  logic [NO-1:0] wave_set = '0, wave_rst = '0, sw_set = '0, sw_rst = '0, burst_idle = '0;
  logic [NO-1:0] oe_set = '0, oe_clr = '0, pol = 2'b10, idle_lvl = 2'b01;
  logic [2*NO-1:0] flt_mode = 4'b0001;
  logic [NF-1:0] fault_in = '0, flt_clr = '0;
  logic [NO-1:0] pin_val, pin_oe;
  logic [2*NO-1:0] out_state;
  logic [NF-1:0] flt_stat;
  logic cnt_rst_out;

  pwm_out_stage #(.N_OUT(NO), .N_FLT(NF)) u_pwm_out_stage (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wave_set(wave_set), .wave_rst(wave_rst),
    .sw_set(sw_set), .sw_rst(sw_rst), .burst_idle(burst_idle), .burst_cnt_rst(burst_cnt_rst),
    .oe_set(oe_set), .oe_clr(oe_clr), .pol(pol), .idle_lvl(idle_lvl), .flt_mode(flt_mode),
    .fault_in(fault_in), .flt_clr(flt_clr), .dbg_stop_en(dbg_stop_en), .dbg_halt(dbg_halt),
    .pin_val(pin_val), .pin_oe(pin_oe), .out_state(out_state), .flt_stat(flt_stat),
    .cnt_rst_out(cnt_rst_out)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string req = "R1";
  bit done = 1'b0;

  // reference model: 0 idle, 1 run, 2 fault
  int m_st[NO];
  int m_lvl[NO];
  int m_stat[NF];
  int m_halt;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NO; i++) begin m_st[i] = 0; m_lvl[i] = 0; end
      for (int k = 0; k < NF; k++) m_stat[k] = 0;
      m_halt = 0;
    end else begin
      bit tr;
      tr = (dbg_stop_en && dbg_halt && m_halt == 0) || (fault_in != 0);
      for (int i = 0; i < NO; i++) begin
        int code;
        code = flt_mode[2*i] + 2 * flt_mode[2*i+1];
        if (oe_clr[i]) m_st[i] = 0;
        else if (tr && code != 0 && (m_st[i] != 0 || oe_set[i])) m_st[i] = 2;
        else if (oe_set[i]) m_st[i] = 1;
        if (sw_rst[i] || (cnt_en && wave_rst[i])) m_lvl[i] = 0;
        else if (sw_set[i] || (cnt_en && wave_set[i])) m_lvl[i] = 1;
      end
      for (int k = 0; k < NF; k++) begin
        if (fault_in[k]) m_stat[k] = 1;
        else if (flt_clr[k]) m_stat[k] = 0;
      end
      m_halt = dbg_halt ? 1 : 0;
    end
  end

  task automatic chk(string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      for (int i = 0; i < NO; i++) begin
        int e_oe, e_val, code;
        code = flt_mode[2*i] + 2 * flt_mode[2*i+1];
        e_oe = 1;
        e_val = idle_lvl[i];
        case (m_st[i])
          1: e_val = (cnt_en && burst_idle[i]) ? idle_lvl[i] : (m_lvl[i] == 1 ? 1 - pol[i] : pol[i]);
          2: begin
               if (code == 3) begin e_oe = 0; e_val = 0; end
               else if (code == 1) e_val = 1 - pol[i];
               else e_val = pol[i];
             end
          default: ;
        endcase
        if (!rst_n) begin e_oe = 0; e_val = 0; end
        chk($sformatf("pin_oe[%0d]", i), pin_oe[i], e_oe);
        chk($sformatf("pin_val[%0d]", i), pin_val[i], e_val);
        chk($sformatf("out_state[%0d]", i), out_state[2*i +: 2], rst_n ? m_st[i] : 0);
      end
      if (rst_n) for (int k = 0; k < NF; k++) chk($sformatf("flt_stat[%0d]", k), flt_stat[k], m_stat[k]);
      chk("cnt_rst_out", cnt_rst_out, (cnt_en && burst_cnt_rst) ? 1 : 0);
    end
  end

  task automatic nxt();
    @(negedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset holds pins tri-stated
    req = "R1";
    repeat (3) nxt();
    rst_n = 1'b1;
    // R2: idle level shown after reset
    req = "R2";
    repeat (2) nxt();
    // R3: enable both; R5 inactive level until first event
    req = "R3";
    oe_set = 2'b11; nxt(); oe_set = '0; nxt(); nxt();
    // R4: hardware events ignored while cnt_en low, software strobes honoured
    req = "R4";
    cnt_en = 0; wave_set = 2'b11; nxt(); wave_set = '0; nxt();
    wave_rst = 2'b11; nxt(); wave_rst = '0; nxt();
    sw_set = 2'b01; nxt(); sw_set = '0; nxt();
    sw_rst = 2'b01; nxt(); sw_rst = '0; nxt();
    // R5: polarity path with cnt_en high, reset wins over set
    req = "R5";
    cnt_en = 1; wave_set = 2'b11; nxt(); wave_set = '0; nxt();
    wave_rst = 2'b01; nxt(); wave_rst = '0; nxt();
    wave_set = 2'b10; wave_rst = 2'b10; nxt(); wave_set = '0; wave_rst = '0; nxt();
    wave_set = 2'b11; nxt(); wave_set = '0; nxt();
    // R6: burst requests gated by cnt_en
    req = "R6";
    burst_idle = 2'b11; burst_cnt_rst = 1; nxt(); cnt_en = 0; nxt(); nxt();
    cnt_en = 1; burst_idle = '0; burst_cnt_rst = 0; nxt();
    // R7: fault trips code-01 output, code-00 output stays in RUN
    req = "R7";
    fault_in = 2'b10; nxt(); fault_in = '0; nxt(); nxt();
    // R11: status clear and set-wins
    req = "R11";
    flt_clr = 2'b10; nxt(); flt_clr = '0; nxt();
    fault_in = 2'b01; flt_clr = 2'b01; nxt(); fault_in = '0; flt_clr = '0; nxt();
    flt_clr = 2'b01; nxt(); flt_clr = '0; nxt();
    // R8: fault pin per code
    req = "R8";
    flt_mode[1:0] = 2'b10; nxt(); flt_mode[1:0] = 2'b11; nxt(); flt_mode[1:0] = 2'b00; nxt();
    flt_mode[1:0] = 2'b01; nxt();
    // R10: waveform moves while faulted, re-enable shows it
    req = "R10";
    wave_rst = 2'b01; nxt(); wave_rst = '0; nxt();
    oe_set = 2'b01; nxt(); oe_set = '0; nxt();
    sw_set = 2'b01; nxt(); sw_set = '0; nxt();
    // R9: halt without stop enable does nothing; with it trips RUN only
    req = "R9";
    flt_mode = 4'b1001;
    oe_clr = 2'b01; nxt(); oe_clr = '0; nxt();
    dbg_halt = 1; nxt(); nxt(); dbg_halt = 0; nxt();
    dbg_stop_en = 1; dbg_halt = 1; nxt(); nxt();
    req = "R11";
    fault_in = 2'b01; nxt(); fault_in = '0; nxt();
    // R10: fault persists after halt ends
    req = "R10";
    dbg_halt = 0; nxt(); nxt(); nxt();
    oe_set = 2'b10; nxt(); oe_set = '0; nxt();
    dbg_halt = 1; nxt(); nxt();
    oe_set = 2'b10; nxt(); oe_set = '0; nxt(); nxt();
    dbg_halt = 0; nxt();
    // R3: disable wins over enable
    req = "R3";
    oe_set = 2'b11; oe_clr = 2'b11; nxt(); oe_set = '0; oe_clr = '0; nxt(); nxt();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule